// File: doc/BRIEF.md
# Segment selector loader

This block fills one of six segment registers from a selector operand. A command names the target register, carries the selector operand and says whether the core runs in real mode or protected mode. In real mode the selector is written and the base is derived from it at once. In protected mode the block checks the selector for null, checks it against the bounds of the local or global descriptor table, and fetches the 8-byte descriptor through a request/acknowledge memory port. It then decodes the descriptor as a data segment and writes the selector, base, limit and attributes into the target register.

Illegal targets raise an undefined-opcode fault. Table, null-stack and descriptor problems raise a general-protection fault that carries the low 16 bits of the selector operand. Any fault abandons the load and leaves the target register as it was. A combinational read port exposes any of the six registers so that the rest of the core can see their contents.

Top module: `seg_sel_loader`

## Requirements
- R1: After reset every register reads selector 0, base 0, limit 0xFFFF and attributes 0, and busy, done and mem_req are low.
- R2: A command whose target is 1 (code segment) or greater than 5 produces done with flt_ud and flt_code 0 one cycle after acceptance. It issues no memory request and changes no register.
- R3: In real mode a command to a legal target writes selector = operand[15:0] and base = operand[15:0] shifted left by 4 (zero-extended). It keeps the limit and the attributes, issues no fetch and signals done one cycle later.
- R4: An operand whose bits above bit 2 are all zero and whose bit 2 is 0 is null. In protected mode a null load into a target other than 2 writes only the selector field and signals done one cycle later.
- R5: A null load into target 2 (stack segment) in protected mode raises flt_gp with flt_code = operand[15:0].
- R6: Operand bit 2 picks the table: 1 selects the local table and 0 selects the global table. The cycle after acceptance, mem_req rises with mem_addr = table base + (operand >> 3) * 8, and both stay unchanged until mem_ack is sampled.
- R7: If (operand >> 3) * 8 + 8 exceeds the chosen table limit, the block raises flt_gp with flt_code = operand[15:0] one cycle after acceptance, without a fetch. All operand bits above bit 2 count, so an oversized operand cannot wrap.
- R8: A local-table access while the local-table selector input is zero raises flt_gp without a fetch.
- R9: On the edge where mem_ack is sampled, the block writes the descriptor into the target: base = {bits 63:56, bits 39:16} and limit = {bits 51:48, bits 15:0}. The block signals done one cycle later.
- R10: When descriptor bit 55 is set, the stored limit is the 20-bit limit shifted left by 12 with the low 12 bits set to ones.
- R11: The stored attributes are [5:4] = DPL (bits 46:45), [3] = default size (bit 54), [2] = expand-down (bit 42), [1] = 1 and [0] = writable (bit 41).
- R12: The block rejects a descriptor that has bit 47 (present) clear, bit 44 (code/data) clear, or bit 43 (code type) set. It raises flt_gp with flt_code = operand[15:0] and leaves the target unchanged. Fault flags appear only together with done.
- R13: A command presented while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load command strobe, accepted when not busy |
| ld_reg | input | 3 | Target register index |
| ld_opnd | input | OPND_W | Selector operand |
| ld_real | input | 1 | 1 = real mode |
| ldt_sel | input | 16 | Local-table selector |
| ldt_base | input | AW | Local-table base |
| ldt_limit | input | LIM_W | Local-table limit |
| gdt_base | input | AW | Global-table base |
| gdt_limit | input | LIM_W | Global-table limit |
| mem_req | output | 1 | Descriptor fetch request |
| mem_addr | output | AW | Descriptor address |
| mem_ack | input | 1 | Fetch response valid |
| mem_rdata | input | 64 | Descriptor data |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle completion pulse |
| flt_gp | output | 1 | General-protection fault, with done |
| flt_ud | output | 1 | Undefined-opcode fault, with done |
| flt_code | output | 16 | Fault error code |
| rd_idx | input | 3 | Read-port register index |
| rd_sel | output | 16 | Selected register selector |
| rd_base | output | AW | Selected register base |
| rd_limit | output | LIM_W | Selected register limit |
| rd_attr | output | 6 | Selected register attributes |

## Verification
Immediate results (undefined-opcode, early protection faults, null and real-mode loads) are due one clock after the accepting edge. A fetch raises mem_req one clock after acceptance, and the register write lands on the edge that samples mem_ack, with done visible one clock after that edge. The bench keeps a behavioural model whose expected outputs change at exactly those edges and compares every output and all six registers at each falling edge. Memory latency varies from zero to several cycles so that the request-hold window is exercised.

// File: rtl/seg_sel_loader.sv
`timescale 1ns/1ps
module seg_sel_loader #(
  parameter int OPND_W = 32,
  parameter int AW     = 32,
  parameter int LIM_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [2:0]        ld_reg,
  input  logic [OPND_W-1:0] ld_opnd,
  input  logic              ld_real,
  input  logic [15:0]       ldt_sel,
  input  logic [AW-1:0]     ldt_base,
  input  logic [LIM_W-1:0]  ldt_limit,
  input  logic [AW-1:0]     gdt_base,
  input  logic [LIM_W-1:0]  gdt_limit,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              flt_gp,
  output logic              flt_ud,
  output logic [15:0]       flt_code,
  input  logic [2:0]        rd_idx,
  output logic [15:0]       rd_sel,
  output logic [AW-1:0]     rd_base,
  output logic [LIM_W-1:0]  rd_limit,
  output logic [5:0]        rd_attr
);
  localparam int NSEG  = 6;
  localparam int IDX_W = OPND_W - 3;
  localparam int OFF_W = OPND_W + 1;
  localparam int CMP_W = (OFF_W > LIM_W) ? OFF_W : LIM_W;
  localparam logic [2:0] R_CS = 3'd1;
  localparam logic [2:0] R_SS = 3'd2;
  localparam logic [2:0] R_LAST = 3'd5;

  typedef enum logic {S_IDLE, S_WAIT} st_t;
  st_t st;

  logic [15:0]      sel_q  [NSEG];
  logic [AW-1:0]    base_q [NSEG];
  logic [LIM_W-1:0] lim_q  [NSEG];
  logic [5:0]       attr_q [NSEG];
  logic [2:0]       tgt_q;
  logic [15:0]      code_q;

  wire [IDX_W-1:0] idx     = ld_opnd[OPND_W-1:3];
  wire             ti      = ld_opnd[2];
  wire             bad_reg = (ld_reg == R_CS) || (ld_reg > R_LAST);
  wire             is_null = (idx == '0) && !ti;
  wire [OFF_W-1:0] off_end = {1'b0, idx, 3'b000} + OFF_W'(8);
  wire [LIM_W-1:0] tbl_lim = ti ? ldt_limit : gdt_limit;
  wire [AW-1:0]    tbl_bas = ti ? ldt_base : gdt_base;
  wire             over    = CMP_W'(off_end) > CMP_W'(tbl_lim);
  wire             ldt_bad = ti && (ldt_sel == 16'd0);
  wire [AW-1:0]    tbl_adr = tbl_bas + AW'({idx, 3'b000});
  wire [AW-1:0]    rm_base = AW'({ld_opnd[15:0], 4'b0000});

  wire             d_bad  = !mem_rdata[47] || !mem_rdata[44] || mem_rdata[43];
  wire [AW-1:0]    d_base = AW'({mem_rdata[63:56], mem_rdata[39:16]});
  wire [19:0]      d_l20  = {mem_rdata[51:48], mem_rdata[15:0]};
  wire [LIM_W-1:0] d_lim  = mem_rdata[55] ? LIM_W'({d_l20, 12'hFFF}) : LIM_W'(d_l20);
  wire [5:0]       d_attr = {mem_rdata[46:45], mem_rdata[54], mem_rdata[42], 1'b1, mem_rdata[41]};
  wire             unused_bits = ^{mem_rdata[53:52], mem_rdata[40]};

  assign busy = (st == S_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      flt_gp   <= 1'b0;
      flt_ud   <= 1'b0;
      flt_code <= '0;
      tgt_q    <= '0;
      code_q   <= '0;
      for (int i = 0; i < NSEG; i++) begin
        sel_q[i]  <= '0;
        base_q[i] <= '0;
        lim_q[i]  <= LIM_W'(16'hFFFF);
        attr_q[i] <= '0;
      end
    end else begin
      done   <= 1'b0;
      flt_gp <= 1'b0;
      flt_ud <= 1'b0;
      case (st)
        S_IDLE: if (ld_valid) begin
          if (bad_reg) begin
            done     <= 1'b1;
            flt_ud   <= 1'b1;
            flt_code <= '0;
          end else if (ld_real) begin
            sel_q[ld_reg]  <= ld_opnd[15:0];
            base_q[ld_reg] <= rm_base;
            done           <= 1'b1;
          end else if (is_null) begin
            done <= 1'b1;
            if (ld_reg == R_SS) begin
              flt_gp   <= 1'b1;
              flt_code <= ld_opnd[15:0];
            end else begin
              sel_q[ld_reg] <= ld_opnd[15:0];
            end
          end else if (ldt_bad || over) begin
            done     <= 1'b1;
            flt_gp   <= 1'b1;
            flt_code <= ld_opnd[15:0];
          end else begin
            st       <= S_WAIT;
            mem_req  <= 1'b1;
            mem_addr <= tbl_adr;
            tgt_q    <= ld_reg;
            code_q   <= ld_opnd[15:0];
          end
        end
        S_WAIT: if (mem_ack) begin
          st      <= S_IDLE;
          mem_req <= 1'b0;
          done    <= 1'b1;
          if (d_bad) begin
            flt_gp   <= 1'b1;
            flt_code <= code_q;
          end else begin
            sel_q[tgt_q]  <= code_q;
            base_q[tgt_q] <= d_base;
            lim_q[tgt_q]  <= d_lim;
            attr_q[tgt_q] <= d_attr;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire rd_ok = (rd_idx <= R_LAST);
  assign rd_sel   = rd_ok ? sel_q[rd_idx]  : '0;
  assign rd_base  = rd_ok ? base_q[rd_idx] : '0;
  assign rd_limit = rd_ok ? lim_q[rd_idx]  : '0;
  assign rd_attr  = rd_ok ? attr_q[rd_idx] : '0;
endmodule

// File: rtl/seg_sel_loader_chk.sv
`timescale 1ns/1ps
module seg_sel_loader_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_valid,
  input logic [2:0]    ld_reg,
  input logic          ld_real,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic          flt_gp,
  input logic          flt_ud
);
  assert_ud_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !busy && (ld_reg == 3'd1 || ld_reg > 3'd5)) |=> (done && flt_ud && !mem_req));

  assert_real_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !busy && ld_real && ld_reg != 3'd1 && ld_reg <= 3'd5) |=> (done && !flt_gp && !flt_ud && !mem_req));

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_req_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_flt_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_gp || flt_ud) |-> (done && !(flt_gp && flt_ud)));

  assert_done_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind seg_sel_loader seg_sel_loader_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_seg_sel_loader.sv
`timescale 1ns/1ps
module sim_seg_sel_loader;
  localparam int CLK_P = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_reg = '0;
  logic [31:0] ld_opnd = '0;
  logic        ld_real = 1'b0;
  logic [15:0] ldt_sel = '0;
  logic [31:0] ldt_base = 32'h8000;
  logic [31:0] ldt_limit = 32'h3F;
  logic [31:0] gdt_base = 32'h1000;
  logic [31:0] gdt_limit = 32'h7F;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        busy, done, flt_gp, flt_ud;
  logic [15:0] flt_code;
  logic [2:0]  rd_idx = '0;
  logic [15:0] rd_sel;
  logic [31:0] rd_base, rd_limit;
  logic [5:0]  rd_attr;

  seg_sel_loader u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  logic [15:0] m_sel [6];
  logic [31:0] m_base [6];
  logic [31:0] m_lim [6];
  logic [5:0]  m_attr [6];
  logic        e_busy = 0, e_done = 0, e_gp = 0, e_ud = 0, e_req = 0;
  logic [15:0] e_code = '0;
  logic [31:0] e_addr = '0;
  string cur_r = "R1";
  int n_tests = 0, n_fail = 0;
  bit mon_on = 0;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_r, what, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    chk("busy", 64'(busy), 64'(e_busy));
    chk("done", 64'(done), 64'(e_done));
    chk("mem_req", 64'(mem_req), 64'(e_req));
    if (e_req) chk("mem_addr", 64'(mem_addr), 64'(e_addr));
    chk("flt_gp", 64'(flt_gp), 64'(e_gp));
    chk("flt_ud", 64'(flt_ud), 64'(e_ud));
    if (e_gp || e_ud) chk("flt_code", 64'(flt_code), 64'(e_code));
    for (int i = 0; i < 6; i++) begin
      rd_idx = 3'(i);
      #1;
      chk("sel", 64'(rd_sel), 64'(m_sel[i]));
      chk("base", 64'(rd_base), 64'(m_base[i]));
      chk("limit", 64'(rd_limit), 64'(m_lim[i]));
      chk("attr", 64'(rd_attr), 64'(m_attr[i]));
    end
  end

  function automatic logic [63:0] mk_desc(logic [31:0] b, logic [19:0] l, bit g, bit d,
                                          logic [1:0] dpl, bit p, bit s, logic [3:0] typ);
    logic [63:0] v;
    v = '0;
    v[15:0] = l[15:0]; v[51:48] = l[19:16];
    v[39:16] = b[23:0]; v[63:56] = b[31:24];
    v[43:40] = typ; v[44] = s; v[46:45] = dpl; v[47] = p; v[54] = d; v[55] = g;
    return v;
  endfunction

  task automatic run(string r, logic [2:0] rg, logic [31:0] op, bit rm,
                     logic [63:0] desc, int lat, bit poke);
    longint idx, lim, tb;
    int kind;
    @(negedge clk);
    cur_r = r;
    ld_valid = 1; ld_reg = rg; ld_opnd = op; ld_real = rm;
    idx = longint'(op) >> 3;
    if (rg == 3'd1 || rg > 3'd5) kind = 1;
    else if (rm) kind = 0;
    else if (idx == 0 && !op[2]) kind = (rg == 3'd2) ? 2 : 4;
    else begin
      lim = op[2] ? longint'(ldt_limit) : longint'(gdt_limit);
      tb  = op[2] ? longint'(ldt_base) : longint'(gdt_base);
      if ((op[2] && ldt_sel == 0) || idx * 8 + 8 > lim) kind = 2;
      else kind = 3;
    end
    @(posedge clk); #1;
    ld_valid = 0; ld_real = 0;
    if (kind != 3) begin
      e_done = 1;
      if (kind == 1) begin e_ud = 1; e_code = 16'd0; end
      if (kind == 2) begin e_gp = 1; e_code = op[15:0]; end
      if (kind == 0) begin m_sel[rg] = op[15:0]; m_base[rg] = 32'(op[15:0]) << 4; end
      if (kind == 4) m_sel[rg] = op[15:0];
    end else begin
      e_busy = 1; e_req = 1; e_addr = 32'(tb + idx * 8);
      if (poke) begin
        @(negedge clk);
        ld_valid = 1; ld_reg = 3'd3; ld_real = 1; ld_opnd = 32'h5555;
        @(posedge clk); #1;
        ld_valid = 0; ld_real = 0;
      end
      repeat (lat) @(posedge clk);
      @(negedge clk);
      mem_ack = 1; mem_rdata = desc;
      @(posedge clk); #1;
      mem_ack = 0; e_busy = 0; e_req = 0; e_done = 1;
      if (!desc[47] || !desc[44] || desc[43]) begin
        e_gp = 1; e_code = op[15:0];
      end else begin
        m_sel[rg]  = op[15:0];
        m_base[rg] = {desc[63:56], desc[39:16]};
        lim = longint'({desc[51:48], desc[15:0]});
        if (desc[55]) lim = lim * 4096 + 4095;
        m_lim[rg]  = 32'(lim);
        m_attr[rg] = 6'(int'(desc[46:45]) * 16 + int'(desc[54]) * 8 + int'(desc[42]) * 4 + 2 + int'(desc[41]));
      end
    end
    @(posedge clk); #1;
    e_done = 0; e_gp = 0; e_ud = 0;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) begin
      m_sel[i] = '0; m_base[i] = '0; m_lim[i] = 32'hFFFF; m_attr[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    cur_r = "R1"; mon_on = 1;
    repeat (2) @(posedge clk);
    // R3 real-mode load
    run("R3", 3'd3, 32'h1234, 1, '0, 0, 0);
    // R2 illegal targets
    run("R2", 3'd1, 32'h0010, 0, '0, 0, 0);
    run("R2", 3'd6, 32'h0010, 0, '0, 0, 0);
    run("R2", 3'd7, 32'h0010, 1, '0, 0, 0);
    // R4 null into data register, R5 null into stack
    run("R4", 3'd0, 32'h0003, 0, '0, 0, 0);
    run("R5", 3'd2, 32'h0001, 0, '0, 0, 0);
    // R8 local table with zero local selector
    run("R8", 3'd4, 32'h000C, 0, '0, 0, 0);
    // R9 R11 R6 global fetch
    run("R9", 3'd3, 32'h0010, 0, mk_desc(32'h12345678, 20'h0ABCD, 0, 1, 2'd2, 1, 1, 4'b0010), 0, 0);
    // R10 granularity
    run("R10", 3'd4, 32'h0018, 0, mk_desc(32'h00400000, 20'h00012, 1, 0, 2'd0, 1, 1, 4'b0011), 2, 0);
    // R6 R11 local table, expand-down read-only
    ldt_sel = 16'h0028;
    run("R6", 3'd5, 32'h000F, 0, mk_desc(32'hA0B0C0D0, 20'hF0000, 0, 1, 2'd3, 1, 1, 4'b0100), 1, 0);
    // R7 bound edge and oversize operand
    run("R7", 3'd0, 32'h0078, 0, '0, 0, 0);
    run("R7", 3'd0, 32'h0070, 0, mk_desc(32'h00001111, 20'h00FFF, 0, 0, 2'd1, 1, 1, 4'b0010), 3, 0);
    run("R7", 3'd3, 32'h0001_0008, 0, '0, 0, 0);
    // R12 rejected descriptors leave stack register untouched
    run("R12", 3'd2, 32'h0020, 0, mk_desc(32'h77777777, 20'h11111, 0, 1, 2'd0, 0, 1, 4'b0010), 0, 0);
    run("R12", 3'd2, 32'h0020, 0, mk_desc(32'h77777777, 20'h11111, 0, 1, 2'd0, 1, 0, 4'b0010), 1, 0);
    run("R12", 3'd2, 32'h0020, 0, mk_desc(32'h77777777, 20'h11111, 0, 1, 2'd0, 1, 1, 4'b1010), 0, 0);
    // R13 command while busy is ignored
    run("R13", 3'd0, 32'h0028, 0, mk_desc(32'h00ABC000, 20'h00200, 0, 1, 2'd0, 1, 1, 4'b0011), 2, 1);
    run("R9", 3'd2, 32'h0008, 0, mk_desc(32'hFEDCBA98, 20'h00001, 1, 1, 2'd0, 1, 1, 4'b0010), 0, 0);
    repeat (2) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule